// File: doc/BRIEF.md
# Parallel I/O Base Address Decoder

This block keeps a bank of programmable base address entries, one for each logical device behind a host I/O bus. For every entry, software sets a 16-bit host address, a 16-bit don't-care mask and an enable flag through a small register port. When the access strobe is high, the incoming 16-bit I/O address is compared against all entries at the same time. The block then reports whether the cycle is claimed, which entries hit, and the index of the lowest entry that hit.

If two or more enabled entries hit the same address, the decoder does not settle the clash quietly by priority. It sets two sticky status flags, one for a general internal error and one for an address overlap. Software clears each flag by writing a 1 to it. The per-entry hit vector shows every entry involved in the clash. The encoded index still points at the lowest of those entries.

Register map: entry `i` holds its base register at word address `2*i` and its mask register at `2*i+1`. The status register is at address `0x20`. Any other address reads as zero.

Top module: `io_bar_decoder`

## Requirements
- R1: While reset is held, each base register returns to its per-entry parameter defaults for address and enable. Each mask goes to zero, both status flags go to 0, and `claim`, `hit_vec` and `hit_idx` go to 0.
- R2: The base register layout is: bits 31:16 hold the host address and bit 15 holds the enable flag. Bit 14, the device-location bit, always reads 0 and ignores writes. Bits 13:0 also read 0. The mask register returns its 16 bits in 15:0 and zeros above them.
- R3: An entry whose enable bit (bit 15) is 0 never hits, even when its address equals the bus address.
- R4: When `io_strobe` is high and an enabled entry's address equals `io_addr`, the next clock sets `claim` to 1 and sets that entry's bit in `hit_vec`.
- R5: A 1 in mask bit `k` of an entry removes address bit `k` from that entry's comparison. A 0 requires the bit to match.
- R6: `hit_idx` is the lowest-numbered entry that hit. When nothing hit, `hit_idx` is 0 and `hit_vec` is all zeros.
- R7: When two or more enabled entries hit during a strobed access, the next clock sets both the error flag (status bit 0) and the conflict flag (status bit 1). `hit_vec` shows every entry that hit.
- R8: The status flags are sticky. A register write to `0x20` with data bit 0 set clears the error flag, and with data bit 1 set clears the conflict flag. If a clearing write and a new conflict arrive in the same cycle, the flag ends up set.
- R9: While `io_strobe` is low, `claim`, `hit_vec` and `hit_idx` read 0 one clock later, and the status flags do not change.
- R10: Decoding uses the entry contents from before the clock edge. A register write in the same cycle as a strobe only affects accesses that come after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write enable |
| reg_addr | input | 6 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from `reg_addr` |
| io_strobe | input | 1 | Qualifies `io_addr` for decoding in this cycle |
| io_addr | input | 16 | Host I/O address under decode |
| claim | output | 1 | Registered: at least one enabled entry hit |
| hit_vec | output | NUM_ENTRIES | Registered: one bit per entry that hit |
| hit_idx | output | IDX_W | Registered: index of the lowest entry that hit |
| sts_err | output | 1 | Sticky internal-error flag |
| sts_conflict | output | 1 | Sticky overlap flag |

## Verification
`claim`, `hit_vec`, `hit_idx` and both status flags come from the clock edge that samples the strobe, so each result is due exactly one clock after its stimulus. The driver task raises the strobe on a falling edge and queues the predicted result, tagged with the cycle in which it is due. The monitor pops each entry one nanosecond after the falling edge of that cycle and compares it, so a result that arrives early or late fails the comparison. Register reads are combinational and are checked in the same cycle their address is driven.

// File: rtl/io_bar_pkg.sv
// Package: shared field positions, register map constants and the entry record
// used by the I/O base address decoder. Assumes 16-bit host I/O addresses.
package io_bar_pkg;
    localparam int HOST_AW     = 16;
    localparam int REG_AW      = 6;
    localparam int BAR_EN_BIT  = 15;
    localparam int MAX_ENTRIES = 16;
    localparam logic [REG_AW-1:0] STS_ADDR = 6'h20;
    localparam int STS_ERR_BIT  = 0;
    localparam int STS_CONF_BIT = 1;

    typedef struct packed {
        logic [HOST_AW-1:0] base;
        logic               en;
        logic [HOST_AW-1:0] mask;
    } bar_entry_t;
endpackage

// File: rtl/bar_entry.sv
// Module: bar_entry
// Storage for one base address entry. It holds the host address, the enable
// flag and the don't-care mask. Assumes the write strobes are already decoded
// by the caller. Bit 14 and bits 13:0 of the base word are never stored.
module bar_entry
    import io_bar_pkg::*;
#(
    parameter logic [HOST_AW-1:0] DEF_BASE  = '0,
    parameter logic               DEF_EN    = 1'b0
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_base,
    input  logic       wr_mask,
    input  logic [31:0] wdata,
    output bar_entry_t ent
);
    // Base field and enable: load from the upper word and bit 15 only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ent.base <= DEF_BASE;
            ent.en   <= DEF_EN;
        end else if (wr_base) begin
            ent.base <= wdata[31:16];
            ent.en   <= wdata[BAR_EN_BIT];
        end
    end

    // Mask field: low half-word of a mask write.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ent.mask <= '0;
        else if (wr_mask)
            ent.mask <= wdata[HOST_AW-1:0];
    end
endmodule

// File: rtl/bar_match.sv
// Module: bar_match
// Compares the bus address against every entry at once. Registers the claim,
// the hit vector and the lowest hit index one clock after the strobe. Also
// drives an unregistered multi-hit flag so the status block can capture it
// on the same edge. Assumes NUM_ENTRIES is between 1 and 16.
module bar_match
    import io_bar_pkg::*;
#(
    parameter int NUM_ENTRIES = 8,
    localparam int IDX_W = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   strobe,
    input  logic [HOST_AW-1:0]     addr,
    input  bar_entry_t             ents [NUM_ENTRIES],
    output logic                   multi_now,
    output logic                   claim,
    output logic [NUM_ENTRIES-1:0] hit_vec,
    output logic [IDX_W-1:0]       hit_idx
);
    logic [NUM_ENTRIES-1:0] raw_hit;
    logic [NUM_ENTRIES-1:0] en_vec;
    logic [IDX_W-1:0]       low_idx;

    // Per-entry comparator: enabled, and every unmasked bit agrees.
    for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_cmp
        assign raw_hit[g] = ents[g].en &&
                            (((addr ^ ents[g].base) & ~ents[g].mask) == '0);
        assign en_vec[g]  = ents[g].en;
    end

    // Lowest-index encoder: scan downward so the smallest hit wins.
    always_comb begin
        low_idx = '0;
        for (int i = NUM_ENTRIES - 1; i >= 0; i--)
            if (raw_hit[i]) low_idx = IDX_W'(i);
    end

    // Two or more hits: clearing the lowest set bit leaves a bit standing.
    assign multi_now = strobe && ((raw_hit & (raw_hit - 1'b1)) != '0);

    // Result register: captured on strobed cycles, cleared otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n || !strobe) begin
            claim   <= 1'b0;
            hit_vec <= '0;
            hit_idx <= '0;
        end else begin
            claim   <= |raw_hit;
            hit_vec <= raw_hit;
            hit_idx <= low_idx;
        end
    end

    p_claim_after_strobe_r9: assert property (@(posedge clk) disable iff (!rst_n)
        claim |-> $past(strobe));
    p_idle_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !strobe |=> (hit_vec == '0 && hit_idx == '0));
    p_enable_gate_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_vec & ~$past(en_vec)) == '0);
    p_lowest_index_r6: assert property (@(posedge clk) disable iff (!rst_n)
        claim |-> (hit_vec[hit_idx] &&
                   ((hit_vec & ((NUM_ENTRIES'(1) << hit_idx) - 1'b1)) == '0)));
endmodule

// File: rtl/bar_status.sv
// Module: bar_status
// Holds the sticky error and conflict flags. A flag is set when multiple
// entries hit and cleared by a write-one-to-clear. Setting takes precedence
// over clearing in the same cycle.
module bar_status (
    input  logic clk,
    input  logic rst_n,
    input  logic multi_now,
    input  logic clr_err,
    input  logic clr_conf,
    output logic err,
    output logic conf
);
    // Error flag: set on overlap, held until cleared.
    always_ff @(posedge clk) begin
        if (!rst_n)         err <= 1'b0;
        else if (multi_now) err <= 1'b1;
        else if (clr_err)   err <= 1'b0;
    end

    // Conflict flag: same policy with its own clear bit.
    always_ff @(posedge clk) begin
        if (!rst_n)         conf <= 1'b0;
        else if (multi_now) conf <= 1'b1;
        else if (clr_conf)  conf <= 1'b0;
    end

    p_overlap_sets_flags_r7: assert property (@(posedge clk) disable iff (!rst_n)
        multi_now |=> (err && conf));
    p_err_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (err && !clr_err) |=> err);
    p_conf_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (conf && !clr_conf) |=> conf);
endmodule

// File: rtl/io_bar_decoder.sv
// Module: io_bar_decoder (top)
// A bank of base address entries with a register port, a parallel address
// decoder and sticky overlap status. Assumes 1 <= NUM_ENTRIES <= 16 so that
// every entry register falls below the status address.
module io_bar_decoder
    import io_bar_pkg::*;
#(
    parameter int NUM_ENTRIES = 8,
    parameter logic [NUM_ENTRIES*HOST_AW-1:0] DEF_BASE = '0,
    parameter logic [NUM_ENTRIES-1:0]         DEF_EN   = '0,
    localparam int IDX_W = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   reg_we,
    input  logic [REG_AW-1:0]      reg_addr,
    input  logic [31:0]            reg_wdata,
    output logic [31:0]            reg_rdata,
    input  logic                   io_strobe,
    input  logic [HOST_AW-1:0]     io_addr,
    output logic                   claim,
    output logic [NUM_ENTRIES-1:0] hit_vec,
    output logic [IDX_W-1:0]       hit_idx,
    output logic                   sts_err,
    output logic                   sts_conflict
);
    bar_entry_t ents [NUM_ENTRIES];
    logic       multi_now;
    logic       sts_wr;

    // Entry bank: each entry decodes its own pair of word addresses.
    for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_ent
        localparam logic [REG_AW-1:0] BASE_A = REG_AW'(2 * g);
        localparam logic [REG_AW-1:0] MASK_A = REG_AW'(2 * g + 1);
        bar_entry #(
            .DEF_BASE (DEF_BASE[g*HOST_AW +: HOST_AW]),
            .DEF_EN   (DEF_EN[g])
        ) u_ent (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_base (reg_we && reg_addr == BASE_A),
            .wr_mask (reg_we && reg_addr == MASK_A),
            .wdata   (reg_wdata),
            .ent     (ents[g])
        );
    end

    bar_match #(.NUM_ENTRIES(NUM_ENTRIES)) u_match (
        .clk       (clk),
        .rst_n     (rst_n),
        .strobe    (io_strobe),
        .addr      (io_addr),
        .ents      (ents),
        .multi_now (multi_now),
        .claim     (claim),
        .hit_vec   (hit_vec),
        .hit_idx   (hit_idx)
    );

    assign sts_wr = reg_we && reg_addr == STS_ADDR;

    bar_status u_sts (
        .clk      (clk),
        .rst_n    (rst_n),
        .multi_now(multi_now),
        .clr_err  (sts_wr && reg_wdata[STS_ERR_BIT]),
        .clr_conf (sts_wr && reg_wdata[STS_CONF_BIT]),
        .err      (sts_err),
        .conf     (sts_conflict)
    );

    // Read mux: base word, mask word or status; zero for unmapped addresses.
    always_comb begin
        reg_rdata = '0;
        if (reg_addr == STS_ADDR) begin
            reg_rdata[STS_ERR_BIT]  = sts_err;
            reg_rdata[STS_CONF_BIT] = sts_conflict;
        end
        for (int i = 0; i < NUM_ENTRIES; i++) begin
            if (reg_addr == REG_AW'(2 * i))
                reg_rdata = {ents[i].base, ents[i].en, 15'b0};
            if (reg_addr == REG_AW'(2 * i + 1))
                reg_rdata = {16'b0, ents[i].mask};
        end
    end

    p_claim_has_hit_r4: assert property (@(posedge clk) disable iff (!rst_n)
        claim == (hit_vec != '0));
    p_multi_claims_r7: assert property (@(posedge clk) disable iff (!rst_n)
        multi_now |=> claim && $countones(hit_vec) > 1);
endmodule

// File: tb/tb_io_bar_decoder.sv
// Scoreboard bench: the access task predicts each result from its own model
// and queues it; the monitor compares queued items in the cycle they are due.
module tb_io_bar_decoder;
    localparam int N = 8;
    localparam int IW = 3;

    logic clk = 0;
    logic rst_n = 0;
    logic reg_we = 0;
    logic [5:0] reg_addr = 0;
    logic [31:0] reg_wdata = 0;
    logic [31:0] reg_rdata;
    logic io_strobe = 0;
    logic [15:0] io_addr = 0;
    logic claim;
    logic [N-1:0] hit_vec;
    logic [IW-1:0] hit_idx;
    logic sts_err, sts_conflict;

    always #5 clk = ~clk;

    io_bar_decoder #(
        .NUM_ENTRIES(N),
        .DEF_BASE({{(N-1){16'h0000}}, 16'h0060}),
        .DEF_EN(8'b0000_0001)
    ) dut (.*);

    typedef struct {
        logic          claim;
        logic [N-1:0]  vec;
        logic [IW-1:0] idx;
        logic          err;
        logic          conf;
        int            due;
        string         req;
    } exp_t;

    exp_t q[$];
    int cyc = 0;
    int checks = 0;
    int fails = 0;

    logic [15:0] m_base [N];
    logic        m_en   [N];
    logic [15:0] m_mask [N];
    logic        m_err = 0, m_conf = 0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        reg_we = 1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 0;
        if (a == 6'h20) begin
            if (d[0]) m_err = 0;
            if (d[1]) m_conf = 0;
        end else if (a[0]) m_mask[a[4:1]] = d[15:0];
        else begin
            m_base[a[4:1]] = d[31:16];
            m_en[a[4:1]] = d[15];
        end
    endtask

    task automatic rd(input logic [5:0] a, input logic [31:0] exp, input string req);
        reg_addr = a;
        #1;
        chk(req, reg_rdata, exp);
        @(negedge clk);
    endtask

    // Driver: strobe one cycle, predict from the model, optionally clear
    // status in the same cycle (set must win).
    task automatic access(input logic [15:0] a, input string req,
                          input logic [1:0] clr = 2'b00);
        exp_t e;
        int hits = 0;
        e.vec = '0; e.idx = '0;
        for (int i = N - 1; i >= 0; i--)
            if (m_en[i] && (((a ^ m_base[i]) & ~m_mask[i]) == 16'h0)) begin
                e.vec[i] = 1'b1; e.idx = IW'(i); hits++;
            end
        e.claim = (hits > 0);
        if (clr[0]) m_err = 0;
        if (clr[1]) m_conf = 0;
        if (hits > 1) begin m_err = 1; m_conf = 1; end
        e.err = m_err; e.conf = m_conf;
        e.due = cyc + 1; e.req = req;
        q.push_back(e);
        io_strobe = 1; io_addr = a;
        if (clr != 0) begin reg_we = 1; reg_addr = 6'h20; reg_wdata = {30'b0, clr}; end
        @(negedge clk);
        io_strobe = 0; reg_we = 0;
    endtask

    // Monitor: compare the head item in the cycle it is due.
    initial begin
        forever begin
            @(negedge clk);
            #1;
            if (q.size() > 0 && q[0].due == cyc) begin
                exp_t e;
                e = q.pop_front();
                chk({e.req, " claim"}, 32'(claim), 32'(e.claim));
                chk({e.req, " hit_vec"}, 32'(hit_vec), 32'(e.vec));
                chk({e.req, " hit_idx"}, 32'(hit_idx), 32'(e.idx));
                chk({e.req, " status"}, {30'b0, sts_conflict, sts_err}, {30'b0, e.conf, e.err});
            end
        end
    end

    initial begin
        #2_000_000;
        fails++;
        $display("FAIL watchdog: actual hung expected done");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        for (int i = 0; i < N; i++) begin m_base[i] = 0; m_en[i] = 0; m_mask[i] = 0; end
        m_base[0] = 16'h0060; m_en[0] = 1;
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1: reset contents
        rd(6'h00, 32'h0060_8000, "R1 base0 default");
        rd(6'h01, 32'h0, "R1 mask0 zero");
        rd(6'h02, 32'h0, "R1 base1 default");
        rd(6'h20, 32'h0, "R1 status clear");
        chk("R1 claim idle", {31'b0, claim}, 32'h0);
        // R4: exact hit on a default-enabled entry
        access(16'h0060, "R4 default entry");
        // R2: reserved and device bits drop
        wr(6'h02, 32'h03F8_FFFF);
        rd(6'h02, 32'h03F8_8000, "R2 base readback");
        wr(6'h03, 32'hFFFF_0000);
        rd(6'h03, 32'h0, "R2 mask upper ignored");
        access(16'h03F8, "R4 entry1 hit");
        // R3: disabled entry with matching address
        wr(6'h04, 32'h0300_4000);
        rd(6'h04, 32'h0300_0000, "R2 device bit reads zero");
        access(16'h0300, "R3 disabled entry");
        // R5: mask
        wr(6'h06, 32'h0070_8000);
        wr(6'h07, 32'h0000_0007);
        access(16'h0075, "R5 masked bits");
        access(16'h0078, "R5 unmasked bit differs");
        // R6/R7: overlap, lowest index and flags
        wr(6'h0A, 32'h03F8_8000);
        access(16'h03F8, "R7 overlap");
        access(16'h0060, "R8 sticky after single hit");
        // R9: idle strobe keeps outputs clear and status held
        repeat (3) @(negedge clk);
        #1;
        chk("R9 claim idle", {31'b0, claim}, 32'h0);
        chk("R9 vec idle", 32'(hit_vec), 32'h0);
        chk("R9 status held", {30'b0, sts_conflict, sts_err}, 32'h3);
        @(negedge clk);
        // R8: per-bit clear
        wr(6'h20, 32'h1);
        rd(6'h20, 32'h2, "R8 clear error only");
        wr(6'h20, 32'h2);
        rd(6'h20, 32'h0, "R8 clear conflict");
        // R8: set wins over simultaneous clear
        access(16'h03F8, "R8 set beats clear", 2'b11);
        rd(6'h20, 32'h3, "R8 set beats clear readback");
        wr(6'h20, 32'h3);
        // R6: no hit gives zero index
        access(16'h1234, "R6 miss");
        // R10: write in same cycle as strobe uses old contents
        q.push_back('{claim:1'b0, vec:'0, idx:'0, err:1'b0, conf:1'b0, due:cyc+1, req:"R10 old contents"});
        io_strobe = 1; io_addr = 16'h0500;
        reg_we = 1; reg_addr = 6'h0C; reg_wdata = 32'h0500_8000;
        @(negedge clk);
        io_strobe = 0; reg_we = 0;
        m_base[6] = 16'h0500; m_en[6] = 1;
        access(16'h0500, "R10 new contents");
        repeat (3) @(negedge clk);
        chk("R4 queue drained", 32'(q.size()), 32'h0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule